// File: doc/BRIEF.md
# Two-Step Transmit Timestamp Queue

This block queues the departure times of frames that need a follow-up timestamp. Each transmit event arrives on a push interface as a port number, a frame identifier and a nanosecond departure time, all in one cycle. Software reads the event back as two consecutive queue entries. The first is the time entry: the transmit flag is set, the port field shows the egress port and the stamp word holds the nanosecond time. The second is the identifier entry: the transmit flag is clear and the stamp word holds the frame identifier, zero-extended. Software uses the identifier to match the time to the frame it sent.

Software sees a view of the head entry made of four fields: valid, overflow, transmit flag and port. Next to it sits the stamp word. A one-cycle pulse on `pop_next` drops the head entry and shows the entry behind it. When valid reads low the queue holds nothing and software stops reading. Storage is counted in event pairs, and `DEPTH` must be a power of two. When the queue is full, an arriving event is refused as a whole, so a time entry is never stored without its identifier. A sticky overflow flag records the loss.

Top module: `txstamp_queue`

## Requirements
- R1: After reset, q_valid, q_ovfl, q_is_tx, q_port and q_stamp all read 0.
- R2: A push accepted into an empty queue appears in the cycle after its clock edge as the time entry: q_valid=1, q_is_tx=1, q_port equal to the pushed port, q_stamp equal to the pushed nanosecond value.
- R3: Popping a time entry shows, in the next cycle, the identifier entry of the same event: q_valid=1, q_is_tx=0, the same q_port, and q_stamp equal to the identifier zero-extended.
- R4: Popping an identifier entry shows, in the next cycle, the time entry of the next stored event. If no event is left, it shows q_valid=0, with q_is_tx, q_port and q_stamp reading 0.
- R5: Up to DEPTH events are held and come out in push order, each one as its time entry followed by its identifier entry.
- R6: A push that arrives while DEPTH events are stored is dropped completely, even if a pop happens in the same cycle. The stored events and their order stay the same.
- R7: q_ovfl goes to 1 in the cycle after a push is dropped, and it stays at 1 until reset.
- R8: A pop on an empty queue has no effect. The queue stays empty, and a later push behaves as described in R2.
- R9: A push and a pop in the same cycle both take effect. This includes the case where the pop removes the last stored entry.
- R10: Frame identifiers from 0 to 511 come back unchanged, including after the identifier sequence wraps from 511 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| push_vld | input | 1 | Transmit event present this cycle |
| push_port | input | PORT_W | Egress port of the event |
| push_id | input | ID_W | Frame identifier of the event |
| push_ns | input | NS_W | Nanosecond departure time |
| pop_next | input | 1 | One-cycle pulse that drops the head entry |
| q_valid | output | 1 | Head entry present |
| q_ovfl | output | 1 | Sticky flag: an event was dropped |
| q_is_tx | output | 1 | Head entry is a time entry |
| q_port | output | PORT_W | Egress port of the head event |
| q_stamp | output | max(NS_W,ID_W) | Nanosecond time or frame identifier |

## Verification
The assertions assume that `pop_next` is a single-cycle pulse and that `push_vld` carries at most one event per cycle. They also assume that reset is held long enough for at least one clock edge. The stimulus drives every input half a cycle away from the sampling edge. Inputs return to idle after each step. Pops are issued whether or not the queue holds anything, so the empty-pop case occurs on purpose and is never filtered out. The streaming phase alternates one push with two pops. This keeps the queue near empty, so the cycle in which a pop drains the last entry while a new event is written comes up again and again.

// File: rtl/txq_pkg.sv
package txq_pkg;

  function automatic int unsigned wmax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/txq_mem.sv
module txq_mem #(
  parameter int W  = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int N = 1 << AW;

  logic [W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (we && (waddr == raddr)) rdata <= wdata;
    else                        rdata <= mem[raddr];
  end
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_vld,
  input  logic          pop_req,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          valid,
  output logic          phase,
  output logic          ovfl
);
  logic [AW-1:0] head, tail, head_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          full, empty, push_ok, pop_ok, pair_done;

  always_comb begin
    full      = (cnt == CW'(DEPTH));
    empty     = (cnt == '0);
    push_ok   = push_vld && !full;
    pop_ok    = pop_req && !empty;
    pair_done = pop_ok && phase;
    head_n    = head + AW'(pair_done);
    cnt_n     = cnt + CW'(push_ok) - CW'(pair_done);
  end

  assign wr_en   = push_ok;
  assign wr_addr = tail;
  assign rd_addr = head_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      tail  <= '0;
      cnt   <= '0;
      phase <= 1'b0;
      valid <= 1'b0;
      ovfl  <= 1'b0;
    end else begin
      head  <= head_n;
      tail  <= tail + AW'(push_ok);
      cnt   <= cnt_n;
      phase <= phase ^ pop_ok;
      valid <= (cnt_n != '0);
      ovfl  <= ovfl | (push_vld && full);
    end
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  // R6
  drop_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (push_vld && full) |=> ovfl);

  // R7
  ovfl_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovfl |=> ovfl);

  // R8
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_req && empty && !push_vld) |=> (cnt == '0) && !phase);
endmodule

// File: rtl/txstamp_queue.sv
module txstamp_queue #(
  parameter int DEPTH  = 16,
  parameter int PORT_W = 3,
  parameter int NS_W   = 30,
  parameter int ID_W   = 9,
  localparam int SW    = txq_pkg::wmax(NS_W, ID_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_vld,
  input  logic [PORT_W-1:0] push_port,
  input  logic [ID_W-1:0]   push_id,
  input  logic [NS_W-1:0]   push_ns,
  input  logic              pop_next,
  output logic              q_valid,
  output logic              q_ovfl,
  output logic              q_is_tx,
  output logic [PORT_W-1:0] q_port,
  output logic [SW-1:0]     q_stamp
);
  localparam int AW = $clog2(DEPTH);
  localparam int TW = NS_W + PORT_W;

  logic          wr_en, valid, phase, ovfl;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [TW-1:0] time_rd;
  logic [ID_W-1:0] id_rd;

  txq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .push_vld(push_vld), .pop_req(pop_next),
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .valid(valid), .phase(phase), .ovfl(ovfl)
  );

  txq_mem #(.W(TW), .AW(AW)) u_time_mem (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata({push_port, push_ns}),
    .raddr(rd_addr), .rdata(time_rd)
  );

  txq_mem #(.W(ID_W), .AW(AW)) u_id_mem (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(push_id),
    .raddr(rd_addr), .rdata(id_rd)
  );

  always_comb begin
    q_valid = valid;
    q_ovfl  = ovfl;
    q_is_tx = valid && !phase;
    q_port  = valid ? time_rd[TW-1:NS_W] : '0;
    if (!valid)     q_stamp = '0;
    else if (phase) q_stamp = SW'(id_rd);
    else            q_stamp = SW'(time_rd[NS_W-1:0]);
  end

  // R3
  tx_then_id_chk: assert property (@(posedge clk) disable iff (rst)
    (q_valid && q_is_tx && pop_next) |=> (q_valid && !q_is_tx));

  // R4
  id_then_next_chk: assert property (@(posedge clk) disable iff (rst)
    (q_valid && !q_is_tx && pop_next) |=> (!q_valid || q_is_tx));
endmodule

// File: tb/tb_txstamp_queue.sv
`timescale 1ns/1ps
module tb_txstamp_queue;
  localparam int DEPTH = 16;
  localparam int PW = 3;
  localparam int NW = 30;
  localparam int IW = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic push_vld = 1'b0;
  logic [PW-1:0] push_port = '0;
  logic [IW-1:0] push_id = '0;
  logic [NW-1:0] push_ns = '0;
  logic pop_next = 1'b0;
  logic q_valid, q_ovfl, q_is_tx;
  logic [PW-1:0] q_port;
  logic [NW-1:0] q_stamp;

  int total = 0;
  int bad = 0;

  logic [NW-1:0] mns [DEPTH];
  logic [IW-1:0] mid [DEPTH];
  logic [PW-1:0] mport [DEPTH];
  int mhead, mtail, mcnt;
  logic mphase, movf;

  always #2.5 clk = ~clk;

  txstamp_queue #(.DEPTH(DEPTH), .PORT_W(PW), .NS_W(NW), .ID_W(IW)) dut (
    .clk(clk), .rst(rst), .push_vld(push_vld), .push_port(push_port),
    .push_id(push_id), .push_ns(push_ns), .pop_next(pop_next),
    .q_valid(q_valid), .q_ovfl(q_ovfl), .q_is_tx(q_is_tx),
    .q_port(q_port), .q_stamp(q_stamp)
  );

  function automatic logic [NW-1:0] ns_of(input int i);
    logic [63:0] v;
    v = 64'(i) * 64'h9E3779B + 64'd17;
    return v[NW-1:0];
  endfunction

  task automatic chk(input string tag);
    logic ev, etx;
    logic [PW-1:0] ep;
    logic [NW-1:0] es;
    ev  = (mcnt != 0);
    etx = ev && !mphase;
    ep  = ev ? mport[mhead] : '0;
    es  = !ev ? '0 : (mphase ? NW'(mid[mhead]) : mns[mhead]);
    total++;
    if (q_valid !== ev || q_is_tx !== etx || q_port !== ep ||
        q_stamp !== es || q_ovfl !== movf) begin
      bad++;
      $display("FAIL %s: actual v=%0b tx=%0b port=%0d stamp=%0h ovf=%0b expected v=%0b tx=%0b port=%0d stamp=%0h ovf=%0b",
               tag, q_valid, q_is_tx, q_port, q_stamp, q_ovfl, ev, etx, ep, es, movf);
    end
  endtask

  // called at a negedge: drive, model the edge, wait one cycle, check
  task automatic step(input logic psh, input int idx, input logic pop, input string tag);
    logic full;
    push_vld  = psh;
    push_port = PW'(idx);
    push_id   = IW'(idx);
    push_ns   = ns_of(idx);
    pop_next  = pop;
    full = (mcnt == DEPTH);
    if (psh && full) movf = 1'b1;
    if (pop && mcnt != 0) begin
      if (mphase) begin
        mhead = (mhead + 1) % DEPTH;
        mcnt--;
        mphase = 1'b0;
      end else mphase = 1'b1;
    end
    if (psh && !full) begin
      mns[mtail] = ns_of(idx);
      mid[mtail] = IW'(idx);
      mport[mtail] = PW'(idx);
      mtail = (mtail + 1) % DEPTH;
      mcnt++;
    end
    @(negedge clk);
    push_vld = 1'b0;
    pop_next = 1'b0;
    chk(tag);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mhead = 0; mtail = 0; mcnt = 0; mphase = 1'b0; movf = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 reset state");

    // single event through both entries
    step(1'b1, 5, 1'b0, "R2 push into empty");
    step(1'b0, 0, 1'b1, "R3 id entry follows");
    step(1'b0, 0, 1'b1, "R4 drained to empty");

    // pops on empty queue
    step(1'b0, 0, 1'b1, "R8 pop empty");
    step(1'b0, 0, 1'b1, "R8 pop empty again");
    step(1'b1, 77, 1'b0, "R8 push after empty pop");
    step(1'b0, 0, 1'b1, "R3 id after empty-pop push");
    step(1'b0, 0, 1'b1, "R4 empty again");

    // fill, overflow, drain
    for (int i = 0; i < DEPTH; i++) step(1'b1, 100 + i, 1'b0, "R5 fill");
    step(1'b1, 999, 1'b0, "R6 push while full");
    step(1'b1, 998, 1'b1, "R6 push with pop while full");
    step(1'b0, 0, 1'b0, "R7 flag holds");
    for (int i = 0; i < 2 * DEPTH + 2; i++) step(1'b0, 0, 1'b1, "R5 drain order");
    step(1'b0, 0, 1'b0, "R7 flag holds after drain");

    do_reset();
    chk("R7 flag cleared by reset");

    // stream: one push per two cycles, pop every cycle; ids wrap past 511
    for (int i = 0; i < 600; i++) begin
      step(1'b1, i, 1'b1, "R9 push and pop together");
      step(1'b0, 0, 1'b1, "R10 id round trip");
    end

    // stream with a backlog: push every cycle, pop every cycle
    for (int i = 0; i < 40; i++) step(1'b1, 300 + i, 1'b1, "R9 backlog stream");
    for (int i = 0; i < 2 * DEPTH + 4; i++) step(1'b0, 0, 1'b1, "R5 backlog drain");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule